// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Controller

This block connects a simple register/window bus to one SPI NOR flash device on a single chip select. The bus carries a select between a small register file and a flash window, plus byte, halfword and word sizes. The SPI side is single-bit and uses mode 0: SCK idles low, data changes on the falling edge and is sampled on the rising edge, most significant bit first.

In manual mode, software holds the chip select low through a stop bit in the control register. Each window write shifts its bytes out, and each window read clocks in as many bytes as the access is wide. The byte in lane 0 always travels first, so multi-byte values appear big-endian on the wire. In the automatic modes, each window access at offset A becomes a complete flash command. The command is the opcode held in the control register, then A with the most significant byte first (three or four bytes), then an optional dummy byte for fast read, then the data. After the data the chip select is released. Any access that needs SPI traffic holds the bus ready low until its last bit has been shifted. A register access completes in the cycle it is presented.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Register accesses (bus_win=0) complete with bus_ready high in the same cycle. After reset all implemented register bits read 0. Only these bits exist, and all others read 0: offset 0x00 bit 16 (window write enable); offset 0x04 bit 0 (32-bit addressing); offset 0x10 bits [1:0] (mode: 0 read, 1 fast read, 2 write, 3 manual), bit 2 (chip-select stop) and bits [23:16] (command opcode).
- R2: Outside an automatic command, spi_cs_n is low exactly when the mode is 3 and the stop bit is 0. Each manual session shows one falling edge of spi_cs_n.
- R3: In manual mode with writes enabled, a window write shifts out 1, 2 or 4 bytes (bus_size 0, 1, 2), lane 0 (bus_wdata[7:0]) first, each byte MSB first.
- R4: In manual mode, a window read clocks in 1, 2 or 4 bytes. The first received byte lands in bus_rdata[7:0], and unused upper lanes read 0.
- R5: A window write with the enable bit clear, or any window access in manual mode while the stop bit is set, produces no SPI traffic and gets bus_ready in the same cycle.
- R6: In modes 0 and 2, a window word read at offset A sends the opcode, then A[23:16], A[15:8], A[7:0] (when 32-bit addressing is off), then clocks in 4 data bytes, with the first one in bus_rdata[7:0], all inside one chip-select low period.
- R7: With 32-bit addressing on, the address phase of a read or write command is four bytes, A[31:24] first.
- R8: In mode 1, one dummy byte of 0x00 follows the address before the data bytes.
- R9: In mode 2, a window word write at offset A sends the opcode, the address, then bus_wdata lanes 0 to 3, and then raises spi_cs_n.
- R10: An SCK high phase lasts CLK_DIV/2 clock cycles. Within a byte, rising edges are CLK_DIV cycles apart. bus_ready stays low while a byte is shifting.
- R11: spi_cs_n changes only while SCK is low and no byte is shifting. SCK is never high while spi_cs_n is high.
- R12: A window write in mode 0 or 1 is dropped with no SPI traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_win | input | 1 | 1 selects the flash window, 0 selects registers |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Register offset or window offset |
| bus_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes in this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can fall in the same cycle: the last falling SCK edge of a command, and the chip-select release that ends that command. The other meeting point is a chip-select change, made by a register write, landing next to a finished byte. Both are provoked by running automatic commands back to back and by opening and closing manual sessions between window accesses. A monitor on the chip-select edges records whether SCK was high at any edge. The flash model also counts chip-select sessions and checks that each command's whole byte stream fell inside exactly one of them.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
   typedef enum logic [1:0] {
      MODE_RD   = 2'd0,
      MODE_FRD  = 2'd1,
      MODE_WR   = 2'd2,
      MODE_USER = 2'd3
   } sfc_mode_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOAD = 2'd1,
      S_WAIT = 2'd2,
      S_DONE = 2'd3
   } sfc_seq_e;

   localparam logic [7:0] OFF_CFG = 8'h00;
   localparam logic [7:0] OFF_CSC = 8'h04;
   localparam logic [7:0] OFF_CTL = 8'h10;
   localparam int CFG_WEN_BIT = 16;
   localparam int CSC_A32_BIT = 0;
   localparam int CTL_STOP_BIT = 2;
   localparam int CTL_OP_LSB = 16;
endpackage

// File: rtl/sfc_shifter.sv
`timescale 1ns/1ps
module sfc_shifter #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx
);
   localparam int HALF = CLK_DIV / 2;
   localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

   logic       tick;
   logic [2:0] bitn;
   logic [7:0] txsh;
   logic [7:0] rxsh;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (HALF == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         logic [DW-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        div <= '0;
            else if (!busy)                    div <= '0;
            else if (div == DW'(HALF - 1))     div <= '0;
            else                               div <= div + 1'b1;
         end
         assign tick = busy && (div == DW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         sck  <= 1'b0;
         bitn <= '0;
         txsh <= '0;
         rxsh <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            txsh <= tx;
            bitn <= '0;
            sck  <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck  <= 1'b1;
               rxsh <= {rxsh[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bitn == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
                  txsh <= {txsh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = txsh[7];
   assign rx   = rxsh;
endmodule

// File: rtl/sfc_seq.sv
`timescale 1ns/1ps
module sfc_seq
   import sfc_pkg::*;
#(
   parameter int ADDR_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              direct,
   input  logic              a32,
   input  logic              dummy,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [7:0]        opcode,
   output logic              sh_start,
   output logic [7:0]        sh_tx,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx,
   output logic              idle,
   output logic              done,
   output logic              dir_act,
   output logic [31:0]       rdata
);
   sfc_seq_e   st;
   logic [3:0] idx, hdr_q, last_q;
   logic [2:0] alen_q;
   logic       dir_q, wr_q;
   logic [7:0] op_q;
   logic [31:0] addr_q, wdata_q;
   logic [3:0] hdr_n, nd_n;
   logic [1:0] lane;
   logic [2:0] ashift;

   always_comb begin
      hdr_n = direct ? 4'(1 + (a32 ? 4 : 3) + (dummy ? 1 : 0)) : 4'd0;
      case (size)
         2'd0:    nd_n = 4'd1;
         2'd1:    nd_n = 4'd2;
         default: nd_n = 4'd4;
      endcase
   end

   assign lane   = 2'(idx - hdr_q);
   assign ashift = alen_q - idx[2:0];

   always_comb begin
      if (dir_q && idx == 4'd0)               sh_tx = op_q;
      else if (dir_q && idx <= {1'b0, alen_q}) sh_tx = 8'(addr_q >> {ashift, 3'b000});
      else if (idx < hdr_q)                   sh_tx = 8'h00;
      else if (wr_q)                          sh_tx = wdata_q[{lane, 3'b000} +: 8];
      else                                    sh_tx = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         idx     <= '0;
         hdr_q   <= '0;
         last_q  <= '0;
         alen_q  <= '0;
         dir_q   <= 1'b0;
         wr_q    <= 1'b0;
         op_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               dir_q   <= direct;
               wr_q    <= wr;
               op_q    <= opcode;
               addr_q  <= 32'(addr);
               wdata_q <= wdata;
               alen_q  <= a32 ? 3'd4 : 3'd3;
               hdr_q   <= hdr_n;
               last_q  <= hdr_n + nd_n - 4'd1;
               idx     <= '0;
               rdata   <= '0;
               st      <= S_LOAD;
            end
            S_LOAD: st <= S_WAIT;
            S_WAIT: if (sh_done) begin
               if (!wr_q && idx >= hdr_q) rdata[{lane, 3'b000} +: 8] <= sh_rx;
               if (idx == last_q) st <= S_DONE;
               else begin
                  idx <= idx + 4'd1;
                  st  <= S_LOAD;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign sh_start = (st == S_LOAD);
   assign idle     = (st == S_IDLE);
   assign done     = (st == S_DONE);
   assign dir_act  = dir_q && (st == S_LOAD || st == S_WAIT);
endmodule

// File: rtl/spi_flash_ctrl.sv
`timescale 1ns/1ps
module spi_flash_ctrl
   import sfc_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_win,
   input  logic              bus_we,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie between 8 and 32");
      end
   endgenerate

   logic       cfg_wen, cs_a32, ctl_stop;
   logic [1:0] ctl_mode;
   logic [7:0] ctl_op;
   logic       reg_acc, reg_wr;
   logic [7:0] reg_off;
   logic [31:0] reg_rdata;
   sfc_mode_e  mode;
   logic       is_user, acc_drop, launch, eng_active;
   logic       seq_idle, seq_done, seq_dir_act;
   logic [31:0] seq_rdata;
   logic       sh_start, sh_done, sh_busy;
   logic [7:0] sh_tx, sh_rx;

   assign reg_acc = bus_req && !bus_win;
   assign reg_wr  = reg_acc && bus_we;
   assign reg_off = bus_addr[7:0];
   assign mode    = sfc_mode_e'(ctl_mode);
   assign is_user = (mode == MODE_USER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_wen  <= 1'b0;
         cs_a32   <= 1'b0;
         ctl_mode <= 2'd0;
         ctl_stop <= 1'b0;
         ctl_op   <= 8'h00;
      end else if (reg_wr) begin
         case (reg_off)
            OFF_CFG: cfg_wen <= bus_wdata[CFG_WEN_BIT];
            OFF_CSC: cs_a32  <= bus_wdata[CSC_A32_BIT];
            OFF_CTL: begin
               ctl_mode <= bus_wdata[1:0];
               ctl_stop <= bus_wdata[CTL_STOP_BIT];
               ctl_op   <= bus_wdata[CTL_OP_LSB +: 8];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_off)
         OFF_CFG: reg_rdata[CFG_WEN_BIT] = cfg_wen;
         OFF_CSC: reg_rdata[CSC_A32_BIT] = cs_a32;
         OFF_CTL: begin
            reg_rdata[1:0]              = ctl_mode;
            reg_rdata[CTL_STOP_BIT]     = ctl_stop;
            reg_rdata[CTL_OP_LSB +: 8]  = ctl_op;
         end
         default: ;
      endcase
   end

   assign acc_drop = (is_user && ctl_stop) ||
                     (bus_we && (!cfg_wen || mode == MODE_RD || mode == MODE_FRD));
   assign launch   = bus_req && bus_win && !acc_drop && seq_idle;
   assign eng_active = !seq_idle;

   sfc_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(launch),
      .direct(!is_user), .a32(cs_a32), .dummy(mode == MODE_FRD && !bus_we),
      .wr(bus_we), .size(bus_size), .addr(bus_addr), .wdata(bus_wdata),
      .opcode(ctl_op), .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done),
      .sh_rx(sh_rx), .idle(seq_idle), .done(seq_done), .dir_act(seq_dir_act),
      .rdata(seq_rdata)
   );

   sfc_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
      .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done), .rx(sh_rx)
   );

   assign spi_cs_n  = seq_dir_act ? 1'b0 : !(is_user && !ctl_stop);
   assign bus_ready = reg_acc || (bus_req && bus_win && acc_drop && seq_idle) || seq_done;
   assign bus_rdata = bus_win ? seq_rdata : reg_rdata;
endmodule

// File: rtl/sfc_checker.sv
`timescale 1ns/1ps
module sfc_checker #(
   parameter int CLK_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic bus_win,
   input logic bus_we,
   input logic bus_ready,
   input logic cs_n,
   input logic sck,
   input logic eng_busy,
   input logic eng_active,
   input logic wen
);
   localparam int HALF = CLK_DIV / 2;
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_cnt <= '0;
      else if (sck) hi_cnt <= hi_cnt + 16'd1;
      else          hi_cnt <= '0;
   end

   p_reg_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_win) |-> bus_ready);

   p_drop_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_win && bus_we && !wen && !eng_active) |-> bus_ready);

   p_ready_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !bus_ready);

   p_sck_high_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> (hi_cnt == 16'(HALF)));

   p_sck_needs_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   p_cs_rise_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (!eng_busy && !sck));
endmodule

bind spi_flash_ctrl sfc_checker #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
   .bus_we(bus_we), .bus_ready(bus_ready), .cs_n(spi_cs_n), .sck(spi_sck),
   .eng_busy(sh_busy), .eng_active(eng_active), .wen(cfg_wen)
);

// File: tb/spi_flash_ctrl_bench.sv
`timescale 1ns/1ps
module spi_flash_ctrl_bench;
   localparam int CLK_DIV = 4;
   localparam int AW = 28;
   localparam logic [34:0] VEC [6] = '{
      {2'd0, 1'b0, 32'h0001_2340},
      {2'd0, 1'b1, 32'h0A12_3454},
      {2'd1, 1'b0, 32'h00AB_CDE8},
      {2'd1, 1'b1, 32'h0F00_0004},
      {2'd2, 1'b0, 32'h0055_AA00},
      {2'd2, 1'b1, 32'h0180_0010}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_req = 1'b0, bus_win = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_size = 2'd2;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic bus_ready, spi_cs_n, spi_sck, spi_mosi;
   logic spi_miso = 1'b0;

   int ntests = 0, nfail = 0;
   logic [7:0] mlog [256];
   int nlog = 0, nsess = 0, bitc = 0, nbytes = 0, csviol = 0;
   logic [7:0] cur = '0, tmpb;
   time rise_prev = 0, rise_last = 0;

   always #2 clk = ~clk;

   spi_flash_ctrl #(.CLK_DIV(CLK_DIV), .ADDR_W(AW)) u_spi_flash_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
      .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   function automatic logic [7:0] resp(input int k);
      return 8'(8'hA5 + 37 * k);
   endfunction

   always @(negedge spi_cs_n) begin
      bitc = 0; nbytes = 0; nsess++;
      tmpb = resp(0); spi_miso = tmpb[7];
   end
   always @(posedge spi_sck) if (!spi_cs_n) begin
      cur = {cur[6:0], spi_mosi};
      bitc++;
      rise_prev = rise_last; rise_last = $time;
      if (bitc == 8) begin
         if (nlog < 256) mlog[nlog] = cur;
         nlog++; nbytes++; bitc = 0;
      end
   end
   always @(negedge spi_sck) if (!spi_cs_n) begin
      tmpb = resp(nbytes); spi_miso = tmpb[7 - bitc];
   end
   always @(spi_cs_n) if (spi_sck === 1'b1) csviol++;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic win, input logic we, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_win = win; bus_we = we; bus_addr = a;
      bus_size = sz; bus_wdata = wd; cyc = 0;
      #1;
      while (!bus_ready) begin
         @(negedge clk); #1; cyc++;
      end
      rd = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic reg_wr(input logic [7:0] off, input logic [31:0] v);
      logic [31:0] d; int c;
      bus(1'b0, 1'b1, AW'(off), 2'd2, v, d, c);
   endtask

   task automatic reg_rd(input logic [7:0] off, output logic [31:0] v);
      int c;
      bus(1'b0, 1'b0, AW'(off), 2'd2, 32'h0, v, c);
   endtask

   function automatic logic [31:0] ctl(input logic [7:0] op, input logic stop, input logic [1:0] m);
      return {8'h00, op, 13'd0, stop, m};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      ntests++; nfail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      logic [31:0] rd, expd;
      int cyc, b0, s0, alen, h, n, err;
      logic [1:0] m; logic a32; logic [31:0] ad; logic [7:0] op, e;
      string tag;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      reg_rd(8'h00, rd); chk("R1 reset cfg", rd, 32'h0);
      reg_rd(8'h04, rd); chk("R1 reset csc", rd, 32'h0);
      reg_rd(8'h10, rd); chk("R1 reset ctl", rd, 32'h0);
      chk("R2 reset cs_n", {31'b0, spi_cs_n}, 32'h1);
      chk("R10 reset sck", {31'b0, spi_sck}, 32'h0);

      // register masks
      reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, rd); chk("R1 cfg mask", rd, 32'h0001_0000);
      reg_wr(8'h04, 32'hFFFF_FFFF); reg_rd(8'h04, rd); chk("R1 csc mask", rd, 32'h0000_0001);
      reg_wr(8'h10, 32'hFFFF_FFFF); reg_rd(8'h10, rd); chk("R1 ctl mask", rd, 32'h00FF_0007);
      reg_rd(8'h08, rd); chk("R1 unmapped offset", rd, 32'h0);
      chk("R2 manual with stop set", {31'b0, spi_cs_n}, 32'h1);
      reg_wr(8'h04, 32'h0);

      // manual-mode session
      reg_wr(8'h00, 32'h0001_0000);
      reg_wr(8'h10, ctl(8'h00, 1'b1, 2'd3));
      s0 = nsess;
      reg_wr(8'h10, ctl(8'h00, 1'b0, 2'd3));
      chk("R2 manual cs low", {31'b0, spi_cs_n}, 32'h0);
      b0 = nlog;
      bus(1'b1, 1'b1, '0, 2'd2, 32'h0403_0201, rd, cyc);
      chk("R3 word count", nlog - b0, 4);
      chk("R3 word bytes", {mlog[b0], mlog[b0+1], mlog[b0+2], mlog[b0+3]}, 32'h0102_0304);
      bus(1'b1, 1'b1, '0, 2'd0, 32'h1234_56AB, rd, cyc);
      chk("R3 byte write", {24'h0, mlog[b0+4]}, 32'h0000_00AB);
      bus(1'b1, 1'b0, '0, 2'd1, 32'h0, rd, cyc);
      chk("R4 half read", rd, {16'h0, resp(6), resp(5)});
      bus(1'b1, 1'b0, '0, 2'd2, 32'h0, rd, cyc);
      chk("R4 word read", rd, {resp(10), resp(9), resp(8), resp(7)});
      reg_wr(8'h10, ctl(8'h00, 1'b1, 2'd3));
      chk("R2 stop raises cs", {31'b0, spi_cs_n}, 32'h1);
      chk("R2 one session", nsess - s0, 1);

      // dropped accesses
      b0 = nlog;
      bus(1'b1, 1'b1, '0, 2'd2, 32'hFFFF_FFFF, rd, cyc);
      chk("R5 stopped manual write immediate", cyc, 0);
      chk("R5 stopped manual write silent", nlog - b0, 0);
      reg_wr(8'h00, 32'h0);
      reg_wr(8'h10, ctl(8'h00, 1'b0, 2'd3));
      b0 = nlog;
      bus(1'b1, 1'b1, '0, 2'd2, 32'h5555_AAAA, rd, cyc);
      chk("R5 disabled write immediate", cyc, 0);
      chk("R5 disabled write silent", nlog - b0, 0);
      reg_wr(8'h10, ctl(8'h00, 1'b1, 2'd3));
      reg_wr(8'h00, 32'h0001_0000);
      reg_wr(8'h10, ctl(8'h03, 1'b1, 2'd0));
      b0 = nlog; s0 = nsess;
      bus(1'b1, 1'b1, AW'(32'h100), 2'd2, 32'h1111_2222, rd, cyc);
      chk("R12 read-mode write silent", nlog - b0, 0);
      chk("R12 read-mode write no session", nsess - s0, 0);

      // direct write
      reg_wr(8'h04, 32'h1);
      reg_wr(8'h10, ctl(8'h02, 1'b1, 2'd2));
      b0 = nlog; s0 = nsess;
      bus(1'b1, 1'b1, AW'(32'h0150_0000), 2'd2, 32'hDDCC_BBAA, rd, cyc);
      chk("R9 length", nlog - b0, 9);
      chk("R9 opcode+addr", {mlog[b0], mlog[b0+1], mlog[b0+2], mlog[b0+3]}, 32'h0201_5000);
      chk("R7 addr low", {mlog[b0+4], 24'h0}, 32'h0);
      chk("R9 data", {mlog[b0+5], mlog[b0+6], mlog[b0+7], mlog[b0+8]}, 32'hAABB_CCDD);
      chk("R9 cs released", {31'b0, spi_cs_n}, 32'h1);
      chk("R9 one session", nsess - s0, 1);

      // direct read vectors
      for (int i = 0; i < 6; i++) begin
         m = VEC[i][34:33]; a32 = VEC[i][32]; ad = VEC[i][31:0];
         op = 8'(8'h03 + 2 * i);
         tag = a32 ? "R7" : "R6";
         if (m == 2'd1) tag = {tag, "/R8"};
         reg_wr(8'h04, {31'b0, a32});
         reg_wr(8'h10, ctl(op, 1'b1, m));
         b0 = nlog; s0 = nsess;
         bus(1'b1, 1'b0, AW'(ad), 2'd2, 32'h0, rd, cyc);
         alen = a32 ? 4 : 3;
         h = 1 + alen + ((m == 2'd1) ? 1 : 0);
         n = h + 4;
         chk($sformatf("%s vec%0d length", tag, i), nlog - b0, n);
         err = 0;
         for (int k = 0; k < n; k++) begin
            if (k == 0) e = op;
            else if (k <= alen) e = 8'(ad >> (8 * (alen - k)));
            else e = 8'h00;
            if (mlog[b0 + k] !== e) err++;
         end
         chk($sformatf("%s vec%0d stream", tag, i), err, 0);
         chk($sformatf("%s vec%0d data", tag, i), rd,
             {resp(h + 3), resp(h + 2), resp(h + 1), resp(h)});
         chk($sformatf("%s vec%0d session", tag, i), nsess - s0, 1);
         if (i == 0) begin
            chk("R10 ready held", (cyc >= n * 8 * CLK_DIV) ? 1 : 0, 1);
            chk("R10 sck period ns", 32'(rise_last - rise_prev), 32'(CLK_DIV * 4));
         end
      end

      // back-to-back direct commands, then cs edge monitor
      reg_wr(8'h04, 32'h0);
      reg_wr(8'h10, ctl(8'h0B, 1'b1, 2'd1));
      s0 = nsess;
      bus(1'b1, 1'b0, AW'(32'h40), 2'd0, 32'h0, rd, cyc);
      chk("R8 byte read lane0 only", rd, {24'h0, resp(5)});
      bus(1'b1, 1'b0, AW'(32'h44), 2'd1, 32'h0, rd, cyc);
      chk("R8 half read", rd, {16'h0, resp(6), resp(5)});
      chk("R6 two sessions", nsess - s0, 2);
      chk("R11 cs edges with sck high", csviol, 0);

      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule